// File: doc/BRIEF.md
# Triple-DES Word-Serial Sequencer

This block runs one triple-DES operation around an external iterative single-DES engine. A host loads two 64-bit keys and one 64-bit data block through a shared 32-bit write port, one word per cycle, upper word first. One key slot holds the key used in the first and last passes. The other slot holds the key used in the middle pass. A key that appears in both outer passes is therefore loaded only once.

Loading the second word of a data block launches the operation. The block latches the mode bit and drives three engine passes through a start/done handshake. For each pass it supplies the direction and the key slot, and it feeds each pass's result into the next. Encryption runs encrypt, decrypt, encrypt. Decryption runs decrypt, encrypt, decrypt. The 64-bit result then appears on the 32-bit output for two cycles, upper word first, while the ready flag is high. The host port ignores all traffic from launch until the second output word has gone.

Top module: `tdes_seq`

## Requirements
- R1: Host writes are taken one word per cycle while `wr_en` is high and the block is idle. The first word of a pair is the upper half and the second is the lower half. The `wr_sel` value on the second word picks the target: 0 is the outer-pass key slot, 1 is the middle-pass key slot, 2 is the data block, and 3 discards the pair.
- R2: The cycle after a data block's second word is taken, `eng_start` is high with `eng_din` equal to the loaded block.
- R3: When `mode_dec` is 0 at launch, the three passes use (`eng_dec`, `eng_key_sel`) = (0,0), (1,1), (0,0). The result is the third pass's output.
- R4: When `mode_dec` is 1 at launch, the three passes use (1,0), (0,1), (1,0).
- R5: After the third pass's `eng_done`, `ready` is high for exactly two cycles. `dout` shows the result's upper word in the first cycle and its lower word in the second. When `ready` is low, `dout` is zero.
- R6: From launch until the cycle after the second output word, host writes change no key, no data and no word position.
- R7: `mode_dec` is sampled only at launch. Changes during an operation have no effect.
- R8: `eng_done` while no pass is outstanding is ignored and raises no `ready`.
- R9: Reset clears both key slots, the data block, the pass counter and the word position. It also drops `ready` and `eng_start` and returns the block to idle.
- R10: `eng_start` is a one-cycle pulse, issued once per pass, so each operation produces exactly three pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_dec | input | 1 | 0 = encrypt, 1 = decrypt; sampled at launch |
| wr_en | input | 1 | Input word strobe |
| wr_sel | input | 2 | Target of the word pair (0 outer key, 1 middle key, 2 data, 3 discard) |
| wr_data | input | 32 | Input word |
| dout | output | 32 | Result word, zero when not ready |
| ready | output | 1 | Result word valid |
| eng_start | output | 1 | Single-DES pass start pulse |
| eng_dec | output | 1 | Direction of the current pass (1 = decrypt) |
| eng_key_sel | output | 1 | Key slot of the current pass (1 = middle-pass slot) |
| eng_key | output | 64 | Key from the selected slot |
| eng_din | output | 64 | Pass input block |
| eng_done | input | 1 | Pass complete |
| eng_dout | input | 64 | Pass output block |

## Verification
Two events can land in the same cycle: a host write arriving while busy, and the engine reporting a pass complete. When the pass is the last one, the output window also opens in that cycle. The bench stirs random writes and random mode flips into every busy and output cycle, with random engine latency, so these events collide at varied points. It then checks that the result matches a model with the keys loaded before launch. It also checks the three-pass log and runs a following operation that reuses the old keys without reloading them.

// File: rtl/tdes_seq.sv
module tdes_seq #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_dec,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] dout,
  output logic          ready,
  output logic          eng_start,
  output logic          eng_dec,
  output logic          eng_key_sel,
  output logic [2*DW-1:0] eng_key,
  output logic [2*DW-1:0] eng_din,
  input  logic          eng_done,
  input  logic [2*DW-1:0] eng_dout
);
  localparam int BW = 2 * DW;
  localparam logic [1:0] LAST = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_OHI, S_OLO} st_t;

  st_t           st;
  logic [1:0]    pass;
  logic          half;
  logic [DW-1:0] hold;
  logic [BW-1:0] key_o, key_m, blk;
  logic          mode_q, start_q;

  wire take = wr_en && (st == S_IDLE);
  wire mid  = (pass == 2'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; pass <= '0; half <= 1'b0; hold <= '0;
      key_o <= '0; key_m <= '0; blk <= '0; mode_q <= 1'b0; start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      case (st)
        S_IDLE: if (take) begin
          if (!half) begin
            hold <= wr_data;
            half <= 1'b1;
          end else begin
            half <= 1'b0;
            case (wr_sel)
              2'd0: key_o <= {hold, wr_data};
              2'd1: key_m <= {hold, wr_data};
              2'd2: begin
                blk     <= {hold, wr_data};
                mode_q  <= mode_dec;
                pass    <= '0;
                st      <= S_RUN;
                start_q <= 1'b1;
              end
              default: ;
            endcase
          end
        end
        S_RUN: if (eng_done && !start_q) begin
          blk <= eng_dout;
          if (pass == LAST) st <= S_OHI;
          else begin
            pass    <= pass + 2'd1;
            start_q <= 1'b1;
          end
        end
        S_OHI: st <= S_OLO;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ready       = (st == S_OHI) || (st == S_OLO);
  assign dout        = (st == S_OHI) ? blk[BW-1:DW] : (st == S_OLO) ? blk[DW-1:0] : '0;
  assign eng_start   = start_q;
  assign eng_dec     = mode_q ^ mid;
  assign eng_key_sel = mid;
  assign eng_key     = mid ? key_m : key_o;
  assign eng_din     = blk;
endmodule

// File: rtl/tdes_seq_chk.sv
module tdes_seq_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ready,
  input logic [DW-1:0] dout,
  input logic          eng_start,
  input logic          eng_done
);
  // R5
  ready_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |=> ready);
  // R5
  ready_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(ready)) |=> !ready);
  // R5
  dout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (dout == '0));
  // R10
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);
  // R6
  start_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(eng_start && ready));
  // R8
  ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(eng_done));
endmodule

bind tdes_seq tdes_seq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .dout(dout),
  .eng_start(eng_start), .eng_done(eng_done)
);

// File: tb/tdes_seq_bench.sv
module tdes_seq_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_dec = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] dout;
  logic        ready, eng_start, eng_dec, eng_key_sel, eng_done;
  logic [63:0] eng_key, eng_din, eng_dout;
  logic        spur = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [63:0] cur_o = '0, cur_m = '0;

  always #(CLK_P/2) clk = ~clk;

  tdes_seq u_tdes_seq (
    .clk(clk), .rst_n(rst_n), .mode_dec(mode_dec), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .dout(dout), .ready(ready), .eng_start(eng_start),
    .eng_dec(eng_dec), .eng_key_sel(eng_key_sel), .eng_key(eng_key),
    .eng_din(eng_din), .eng_done(eng_done), .eng_dout(eng_dout)
  );

  function automatic logic [63:0] f_enc(input logic [63:0] x, input logic [63:0] k);
    return {x[58:0], x[63:59]} ^ k;
  endfunction
  function automatic logic [63:0] f_dec(input logic [63:0] y, input logic [63:0] k);
    logic [63:0] t;
    t = y ^ k;
    return {t[4:0], t[63:5]};
  endfunction
  function automatic logic [63:0] tdes(input logic [63:0] b, input logic [63:0] ko,
                                       input logic [63:0] km, input logic d);
    if (!d) return f_enc(f_dec(f_enc(b, ko), km), ko);
    return f_dec(f_enc(f_dec(b, ko), km), ko);
  endfunction

  // behavioural single-DES stand-in with random latency
  logic        e_busy = 1'b0, e_done = 1'b0;
  int          e_cnt = 0;
  logic [63:0] e_res = '0;
  int          n_starts = 0;
  logic        lg_dec [0:1023];
  logic        lg_sel [0:1023];
  logic [63:0] lg_din [0:1023];

  always @(posedge clk) begin
    e_done <= 1'b0;
    if (!rst_n) e_busy <= 1'b0;
    else if (eng_start && !e_busy) begin
      e_busy <= 1'b1;
      e_cnt  <= 1 + int'($urandom % 5);
      e_res  <= eng_dec ? f_dec(eng_din, eng_key) : f_enc(eng_din, eng_key);
      lg_dec[n_starts % 1024] <= eng_dec;
      lg_sel[n_starts % 1024] <= eng_key_sel;
      lg_din[n_starts % 1024] <= eng_din;
      n_starts <= n_starts + 1;
    end else if (e_busy) begin
      if (e_cnt == 1) begin e_done <= 1'b1; e_busy <= 1'b0; end
      else e_cnt <= e_cnt - 1;
    end
  end
  assign eng_done = e_done | spur;
  assign eng_dout = e_res;

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [1:0] s, input logic [63:0] v);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = v[63:32];
    @(negedge clk); wr_data = v[31:0];
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic noise_drive(input logic on);
    if (on) begin
      wr_en = 1'($urandom); wr_sel = 2'($urandom); wr_data = $urandom;
      mode_dec = 1'($urandom);
    end
  endtask

  task automatic run_op(input logic [63:0] b, input logic d, input logic noise);
    int base;
    logic got;
    logic [63:0] exp;
    exp = tdes(b, cur_o, cur_m, d);
    mode_dec = d;
    base = n_starts;
    put(2'd2, b);
    // R2: start pulse visible one cycle after the second data word
    chk(eng_start && eng_din == b, "R2", {63'd0, eng_start}, 64'd1);
    got = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (ready) begin got = 1'b1; break; end
      noise_drive(noise);
    end
    chk(got, "R5 ready seen", {63'd0, got}, 64'd1);
    chk(dout == exp[63:32], d ? "R4 upper word" : "R3 upper word", {32'd0, dout}, {32'd0, exp[63:32]});
    noise_drive(noise);
    @(negedge clk);
    chk(ready && dout == exp[31:0], d ? "R4 lower word" : "R3 lower word", {31'd0, ready, dout}, {31'd0, 1'b1, exp[31:0]});
    noise_drive(noise);
    @(negedge clk);
    wr_en = 1'b0; mode_dec = d;
    chk(!ready && dout == '0, "R5 window ends", {31'd0, ready, dout}, 64'd0);
    chk(n_starts - base == 3, "R10 three passes", 64'(n_starts - base), 64'd3);
    for (int p = 0; p < 3; p++) begin
      logic ed, es;
      es = (p == 1);
      ed = d ^ es;
      chk(lg_dec[(base + p) % 1024] == ed && lg_sel[(base + p) % 1024] == es,
          d ? "R4 pass order" : "R3 pass order",
          {62'd0, lg_dec[(base + p) % 1024], lg_sel[(base + p) % 1024]}, {62'd0, ed, es});
    end
  endtask

  task automatic load_keys(input logic [63:0] ko, input logic [63:0] km);
    put(2'd0, ko); put(2'd1, km);
    cur_o = ko; cur_m = km;
  endtask

  initial begin
    logic [63:0] r, b;
    int base;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(!ready && dout == '0 && !eng_start, "R9 reset state", {31'd0, ready, dout}, 64'd0);
    rst_n = 1'b1;

    // R1 R3: directed encrypt
    load_keys(64'h3237_3339_3832_3031, 64'h3438_3536_3233_3839);
    b = 64'h3038_2F32_3030_38FF;
    run_op(b, 1'b0, 1'b0);
    r = tdes(b, cur_o, cur_m, 1'b0);
    // R4: decrypt returns the plaintext
    run_op(r, 1'b1, 1'b0);
    chk(tdes(r, cur_o, cur_m, 1'b1) == b, "R4 round trip", tdes(r, cur_o, cur_m, 1'b1), b);

    // R1: code 3 discards the pair; keys unchanged
    put(2'd3, 64'hDEAD_BEEF_0BAD_F00D);
    run_op(64'h0123_4567_89AB_CDEF, 1'b0, 1'b0);

    // R8: stray done while idle
    base = n_starts;
    @(negedge clk); spur = 1'b1;
    @(negedge clk); spur = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk(!ready && dout == '0, "R8 stray done ignored", {31'd0, ready, dout}, 64'd0);
    end
    chk(n_starts == base, "R8 no start", 64'(n_starts), 64'(base));

    // R9: reset in the middle of an operation
    load_keys(64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888);
    put(2'd2, 64'hAAAA_BBBB_CCCC_DDDD);
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!ready && !eng_start && dout == '0, "R9 mid-op reset", {30'd0, ready, eng_start, dout}, 64'd0);
    rst_n = 1'b1;
    cur_o = '0; cur_m = '0;
    run_op(64'h0F0F_1234_5678_F0F0, 1'b0, 1'b0);

    // R6 R7: random operations with host traffic while busy
    for (int n = 0; n < 40; n++) begin
      if (n == 0 || ($urandom % 3) == 0)
        load_keys({$urandom, $urandom}, {$urandom, $urandom});
      run_op({$urandom, $urandom}, 1'($urandom), 1'b1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule